// File: doc/BRIEF.md
# Centering Display Timing Generator

This block produces the raster timing for one display pipe. It counts pixels along a line and lines along a frame, and it drives the horizontal sync, vertical sync, blanking, active-video and pixel-valid signals. It takes the timing of the attached panel as plain numbers: active size, total size, and blank and sync start/end for each axis. A built-in encoder turns these numbers into the packed timing words that the pipe uses. Each word holds two 16-bit fields, and each field is stored as its value minus one. The encoded words are also brought out so that they can be seen at the ports.

There are two modes. In the scaled mode the panel timing is encoded unchanged. In the unscaled mode, used when a smaller source image is shown without a scaler, the active width and height become the source size. The blank and sync edges are then pulled earlier by half of the size difference. The smaller picture therefore lands in the middle of the panel, even though the hardware has no centering control of its own. The generator only takes new timing words into use at the point where a frame wraps back to its first pixel. A small guard also clears a shared panel-fitter control word when that word says the fitter is enabled on this pipe.

Top module: `ctg_top`

## Requirements
- R1: The horizontal and vertical span words hold (total − 1) in bits 31:16 and (active − 1) in bits 15:0. The active value is the panel active size in scaled mode and the source size in unscaled mode. The totals are always the panel totals.
- R2: In scaled mode (no_scale = 0) the blank words and sync words of each axis hold (end − 1) in bits 31:16 and (start − 1) in bits 15:0, taken from the panel timing without change.
- R3: In unscaled mode, each axis has its own offset, equal to (panel active − source size) divided by two and rounded down. This offset is subtracted from the start and from the end of both blank and sync in that axis before encoding.
- R4: The source word holds (source width − 1) in bits 31:16 and (source height − 1) in bits 15:0.
- R5: hcnt counts 0 up to htotal − 1 and then returns to 0. vcnt changes only on the cycle after hcnt equals htotal − 1; it counts 0 up to vtotal − 1 and then returns to 0.
- R6: hsync is high when start ≤ hcnt < end for the horizontal sync edges. vsync follows the same rule with vcnt and the vertical sync edges. blank is high when either axis lies in its own [blank start, blank end) window. All edges are the values the timing words encode.
- R7: active is high when hcnt < encoded active width and vcnt < encoded active height. pix_valid is high when active is high and blank is low.
- R8: Changes to the timing inputs take effect only from the frame that begins when the counters wrap from (htotal − 1, vtotal − 1) to (0, 0). Until then the generator keeps the previous timing.
- R9: fit_ctl_out equals 0 when bit 31 (enable) of fit_ctl_in is 1 and bits 30:29 equal PIPE_ID. In every other case fit_ctl_out equals fit_ctl_in.
- R10: While rst is high the counters are held at 0 and the timing in use is loaded from the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| no_scale | input | 1 | 1 selects unscaled, centred mode |
| h_active | input | 16 | Panel active width |
| h_total | input | 16 | Panel line length |
| h_blank_start | input | 16 | Panel horizontal blank start |
| h_blank_end | input | 16 | Panel horizontal blank end |
| h_sync_start | input | 16 | Panel horizontal sync start |
| h_sync_end | input | 16 | Panel horizontal sync end |
| v_active | input | 16 | Panel active height |
| v_total | input | 16 | Panel frame length in lines |
| v_blank_start | input | 16 | Panel vertical blank start |
| v_blank_end | input | 16 | Panel vertical blank end |
| v_sync_start | input | 16 | Panel vertical sync start |
| v_sync_end | input | 16 | Panel vertical sync end |
| src_width | input | 16 | Source image width |
| src_height | input | 16 | Source image height |
| fit_ctl_in | input | 32 | Current panel-fitter control word |
| reg_h_span | output | 32 | Encoded horizontal total/active word |
| reg_v_span | output | 32 | Encoded vertical total/active word |
| reg_h_blank | output | 32 | Encoded horizontal blank word |
| reg_h_sync | output | 32 | Encoded horizontal sync word |
| reg_v_blank | output | 32 | Encoded vertical blank word |
| reg_v_sync | output | 32 | Encoded vertical sync word |
| reg_src | output | 32 | Encoded source size word |
| fit_ctl_out | output | 32 | Fitter control word after this pipe is programmed |
| hcnt | output | 16 | Pixel counter |
| vcnt | output | 16 | Line counter |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| blank | output | 1 | Blanking interval |
| active | output | 1 | Inside the active area |
| pix_valid | output | 1 | Pixel strobe: active and not blanked |

## Verification
The bench builds the block with PIPE_ID = 2. This lets the fitter guard tell a matching pipe field apart from a neighbouring value and from a cleared enable bit. The panel timings used are tiny: 20×12 and 18×9 totals. Many whole frames therefore fit in a short run, and each wrap and frame-boundary handover happens several times. The source sizes leave odd differences of 5 and 5, and 3 and 3, so the rounding-down of the centering offset is exercised. Timing is changed in the middle of a frame in both directions to show that the old timing holds until the next frame wrap.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
    localparam int FW = 16;
    localparam int WW = 2 * FW;

    typedef logic [FW-1:0] fld_t;
    typedef logic [WW-1:0] word_t;

    // Panel timing along one axis, in plain units
    typedef struct packed {
        fld_t active;
        fld_t total;
        fld_t blank_start;
        fld_t blank_end;
        fld_t sync_start;
        fld_t sync_end;
    } axis_time_t;

    // Encoded words for one axis
    typedef struct packed {
        word_t span;
        word_t blank;
        word_t sync;
    } axis_regs_t;

    // Decoded minus-one fields used by the counters
    typedef struct packed {
        fld_t last;
        fld_t act_last;
        fld_t blank_from;
        fld_t blank_to;
        fld_t sync_from;
        fld_t sync_to;
    } axis_cfg_t;

    function automatic word_t pack_pair(fld_t lo, fld_t hi);
        return {hi - fld_t'(1), lo - fld_t'(1)};
    endfunction

    function automatic axis_regs_t encode_axis(axis_time_t p, fld_t src, logic centre);
        axis_regs_t r;
        fld_t act;
        fld_t shift;
        act     = centre ? src : p.active;
        shift   = centre ? fld_t'((p.active - src) >> 1) : '0;
        r.span  = pack_pair(act, p.total);
        r.blank = pack_pair(p.blank_start - shift, p.blank_end - shift);
        r.sync  = pack_pair(p.sync_start - shift, p.sync_end - shift);
        return r;
    endfunction

    function automatic axis_cfg_t decode_axis(axis_regs_t r);
        axis_cfg_t c;
        c.last       = r.span[WW-1:FW];
        c.act_last   = r.span[FW-1:0];
        c.blank_to   = r.blank[WW-1:FW];
        c.blank_from = r.blank[FW-1:0];
        c.sync_to    = r.sync[WW-1:FW];
        c.sync_from  = r.sync[FW-1:0];
        return c;
    endfunction
endpackage

// File: rtl/ctg_reg_encoder.sv
module ctg_reg_encoder
    import ctg_pkg::*;
(
    input  axis_time_t h_in,
    input  axis_time_t v_in,
    input  fld_t       src_w,
    input  fld_t       src_h,
    input  logic       centre,
    output axis_regs_t h_regs,
    output axis_regs_t v_regs,
    output word_t      src_reg
);
    assign h_regs  = encode_axis(h_in, src_w, centre);
    assign v_regs  = encode_axis(v_in, src_h, centre);
    assign src_reg = pack_pair(src_h, src_w);
endmodule

// File: rtl/ctg_axis_timer.sv
module ctg_axis_timer
    import ctg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step,
    input  axis_cfg_t cfg,
    output fld_t      cnt,
    output logic      at_last,
    output logic      in_act,
    output logic      in_blank,
    output logic      in_sync
);
    assign at_last = (cnt == cfg.last);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= at_last ? '0 : cnt + fld_t'(1);
    end

    // stored edges are value-1, so [start,end) becomes (from, to]
    assign in_act   = (cnt <= cfg.act_last);
    assign in_blank = (cnt > cfg.blank_from) && (cnt <= cfg.blank_to);
    assign in_sync  = (cnt > cfg.sync_from) && (cnt <= cfg.sync_to);
endmodule

// File: rtl/ctg_fit_guard.sv
module ctg_fit_guard #(
    parameter int          SEL_W   = 2,
    parameter int          SEL_LSB = 29,
    parameter int          EN_BIT  = 31,
    parameter logic [1:0]  PIPE_ID = 2'd0
) (
    input  logic [31:0] ctl_in,
    output logic [31:0] ctl_out
);
    logic owned;
    assign owned   = ctl_in[EN_BIT] && (ctl_in[SEL_LSB +: SEL_W] == PIPE_ID);
    assign ctl_out = owned ? 32'd0 : ctl_in;
endmodule

// File: rtl/ctg_top.sv
module ctg_top
    import ctg_pkg::*;
#(
    parameter logic [1:0] PIPE_ID = 2'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        no_scale,
    input  logic [15:0] h_active,
    input  logic [15:0] h_total,
    input  logic [15:0] h_blank_start,
    input  logic [15:0] h_blank_end,
    input  logic [15:0] h_sync_start,
    input  logic [15:0] h_sync_end,
    input  logic [15:0] v_active,
    input  logic [15:0] v_total,
    input  logic [15:0] v_blank_start,
    input  logic [15:0] v_blank_end,
    input  logic [15:0] v_sync_start,
    input  logic [15:0] v_sync_end,
    input  logic [15:0] src_width,
    input  logic [15:0] src_height,
    input  logic [31:0] fit_ctl_in,
    output logic [31:0] reg_h_span,
    output logic [31:0] reg_v_span,
    output logic [31:0] reg_h_blank,
    output logic [31:0] reg_h_sync,
    output logic [31:0] reg_v_blank,
    output logic [31:0] reg_v_sync,
    output logic [31:0] reg_src,
    output logic [31:0] fit_ctl_out,
    output logic [15:0] hcnt,
    output logic [15:0] vcnt,
    output logic        hsync,
    output logic        vsync,
    output logic        blank,
    output logic        active,
    output logic        pix_valid
);
    axis_time_t h_time, v_time;
    axis_regs_t h_enc, v_enc;
    axis_regs_t h_sh, v_sh;
    axis_cfg_t  h_cfg, v_cfg;
    logic       h_last, v_last, h_act, v_act, h_blk, v_blk;
    logic       frame_wrap;

    assign h_time = '{h_active, h_total, h_blank_start, h_blank_end, h_sync_start, h_sync_end};
    assign v_time = '{v_active, v_total, v_blank_start, v_blank_end, v_sync_start, v_sync_end};

    ctg_reg_encoder u_enc (
        .h_in   (h_time),
        .v_in   (v_time),
        .src_w  (src_width),
        .src_h  (src_height),
        .centre (no_scale),
        .h_regs (h_enc),
        .v_regs (v_enc),
        .src_reg(reg_src)
    );

    assign reg_h_span  = h_enc.span;
    assign reg_h_blank = h_enc.blank;
    assign reg_h_sync  = h_enc.sync;
    assign reg_v_span  = v_enc.span;
    assign reg_v_blank = v_enc.blank;
    assign reg_v_sync  = v_enc.sync;

    // Timing in use: reloaded only at the frame wrap
    assign frame_wrap = h_last && v_last;

    always_ff @(posedge clk) begin
        if (rst || frame_wrap) begin
            h_sh <= h_enc;
            v_sh <= v_enc;
        end
    end

    assign h_cfg = decode_axis(h_sh);
    assign v_cfg = decode_axis(v_sh);

    ctg_axis_timer u_htimer (
        .clk     (clk),
        .rst     (rst),
        .step    (1'b1),
        .cfg     (h_cfg),
        .cnt     (hcnt),
        .at_last (h_last),
        .in_act  (h_act),
        .in_blank(h_blk),
        .in_sync (hsync)
    );

    ctg_axis_timer u_vtimer (
        .clk     (clk),
        .rst     (rst),
        .step    (h_last),
        .cfg     (v_cfg),
        .cnt     (vcnt),
        .at_last (v_last),
        .in_act  (v_act),
        .in_blank(v_blk),
        .in_sync (vsync)
    );

    assign blank     = h_blk || v_blk;
    assign active    = h_act && v_act;
    assign pix_valid = active && !blank;

    ctg_fit_guard #(.PIPE_ID(PIPE_ID)) u_fit (
        .ctl_in (fit_ctl_in),
        .ctl_out(fit_ctl_out)
    );
endmodule

// File: rtl/ctg_checker.sv
module ctg_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] hcnt,
    input logic [15:0] vcnt,
    input logic [15:0] h_end,
    input logic [15:0] v_end,
    input logic [15:0] h_act_end,
    input logic [95:0] h_words,
    input logic        pix_valid
);
    // R5: pixel counter steps by one until the line end
    p_hcnt_step_r5: assert property (@(posedge clk) disable iff (rst)
        (hcnt != h_end) |=> (hcnt == $past(hcnt) + 16'd1));

    // R5: line counter holds inside a line
    p_vcnt_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (hcnt != h_end) |=> $stable(vcnt));

    // R5: last pixel of last line returns to origin
    p_frame_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (hcnt == h_end && vcnt == v_end) |=> (hcnt == 16'd0 && vcnt == 16'd0));

    // R8: timing in use changes only when entering the frame origin
    p_shadow_frame_r8: assert property (@(posedge clk) disable iff (rst)
        (hcnt != 16'd0 || vcnt != 16'd0) |-> $stable(h_words));

    // R7: pixel strobe only inside the active width
    p_pix_in_width_r7: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (hcnt <= h_act_end));
endmodule

bind ctg_top ctg_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .hcnt     (hcnt),
    .vcnt     (vcnt),
    .h_end    (h_cfg.last),
    .v_end    (v_cfg.last),
    .h_act_end(h_cfg.act_last),
    .h_words  (h_sh),
    .pix_valid(pix_valid)
);

// File: tb/ctg_top_test.sv
module ctg_top_test;
    localparam logic [1:0] PIPE = 2'd2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int  in_h[6];
    int  in_v[6];
    int  in_sw, in_sh;
    bit  in_ns;
    logic [31:0] fit_in;

    logic [31:0] r_hs, r_vs, r_hb, r_hy, r_vb, r_vy, r_src, fit_out;
    logic [15:0] hcnt, vcnt;
    logic        hsync, vsync, blank, active, pix_valid;

    ctg_top #(.PIPE_ID(PIPE)) uut (
        .clk(clk), .rst(rst), .no_scale(in_ns),
        .h_active(16'(in_h[0])), .h_total(16'(in_h[1])),
        .h_blank_start(16'(in_h[2])), .h_blank_end(16'(in_h[3])),
        .h_sync_start(16'(in_h[4])), .h_sync_end(16'(in_h[5])),
        .v_active(16'(in_v[0])), .v_total(16'(in_v[1])),
        .v_blank_start(16'(in_v[2])), .v_blank_end(16'(in_v[3])),
        .v_sync_start(16'(in_v[4])), .v_sync_end(16'(in_v[5])),
        .src_width(16'(in_sw)), .src_height(16'(in_sh)),
        .fit_ctl_in(fit_in),
        .reg_h_span(r_hs), .reg_v_span(r_vs), .reg_h_blank(r_hb),
        .reg_h_sync(r_hy), .reg_v_blank(r_vb), .reg_v_sync(r_vy),
        .reg_src(r_src), .fit_ctl_out(fit_out),
        .hcnt(hcnt), .vcnt(vcnt), .hsync(hsync), .vsync(vsync),
        .blank(blank), .active(active), .pix_valid(pix_valid)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int eff_act(int raw, int src, bit ns);
        return ns ? src : raw;
    endfunction
    function automatic int shift_of(int raw, int src, bit ns);
        return ns ? (raw - src) / 2 : 0;
    endfunction
    function automatic logic [31:0] pw(int lo, int hi);
        return {16'(hi - 1), 16'(lo - 1)};
    endfunction

    // Reference model: timing in use and counters
    int  cur_h[6], cur_v[6];
    int  cur_sw, cur_sh;
    bit  cur_ns;
    int  hc = 0, vc = 0;

    task automatic take_inputs();
        cur_h = in_h; cur_v = in_v;
        cur_sw = in_sw; cur_sh = in_sh; cur_ns = in_ns;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            hc = 0; vc = 0; take_inputs();
        end else if (hc == cur_h[1] - 1) begin
            hc = 0;
            if (vc == cur_v[1] - 1) begin
                vc = 0; take_inputs();
            end else vc++;
        end else hc++;
    end

    // Per-cycle comparison in the middle of the high phase
    always @(posedge clk) begin
        #5;
        if (!rst && !done) begin
            int oh, ov, ha, va;
            bit pend, eb, ea;
            string tg;
            oh = shift_of(cur_h[0], cur_sw, cur_ns);
            ov = shift_of(cur_v[0], cur_sh, cur_ns);
            ha = eff_act(cur_h[0], cur_sw, cur_ns);
            va = eff_act(cur_v[0], cur_sh, cur_ns);
            pend = (in_h != cur_h) || (in_v != cur_v) || (in_ns != cur_ns)
                   || (in_sw != cur_sw) || (in_sh != cur_sh);
            chk(hcnt == 16'(hc), "R5 hcnt", hcnt, hc);
            chk(vcnt == 16'(vc), "R5 vcnt", vcnt, vc);
            tg = pend ? "R8 timing held" : "R6 sync/blank";
            chk(hsync == (hc >= cur_h[4] - oh && hc < cur_h[5] - oh), tg, hsync, 0);
            chk(vsync == (vc >= cur_v[4] - ov && vc < cur_v[5] - ov), tg, vsync, 0);
            eb = (hc >= cur_h[2] - oh && hc < cur_h[3] - oh) ||
                 (vc >= cur_v[2] - ov && vc < cur_v[3] - ov);
            chk(blank == eb, tg, blank, eb);
            ea = (hc < ha) && (vc < va);
            chk(active == ea, "R7 active", active, ea);
            chk(pix_valid == (ea && !eb), "R7 pix_valid", pix_valid, ea && !eb);
            begin
                int ih, iv;
                ih = shift_of(in_h[0], in_sw, in_ns);
                iv = shift_of(in_v[0], in_sh, in_ns);
                chk(r_hs == pw(eff_act(in_h[0], in_sw, in_ns), in_h[1]), "R1 h span", r_hs,
                    pw(eff_act(in_h[0], in_sw, in_ns), in_h[1]));
                chk(r_vs == pw(eff_act(in_v[0], in_sh, in_ns), in_v[1]), "R1 v span", r_vs,
                    pw(eff_act(in_v[0], in_sh, in_ns), in_v[1]));
                tg = in_ns ? "R3 centred edges" : "R2 plain edges";
                chk(r_hb == pw(in_h[2] - ih, in_h[3] - ih), tg, r_hb, pw(in_h[2] - ih, in_h[3] - ih));
                chk(r_hy == pw(in_h[4] - ih, in_h[5] - ih), tg, r_hy, pw(in_h[4] - ih, in_h[5] - ih));
                chk(r_vb == pw(in_v[2] - iv, in_v[3] - iv), tg, r_vb, pw(in_v[2] - iv, in_v[3] - iv));
                chk(r_vy == pw(in_v[4] - iv, in_v[5] - iv), tg, r_vy, pw(in_v[4] - iv, in_v[5] - iv));
                chk(r_src == pw(in_sh, in_sw), "R4 source word", r_src, pw(in_sh, in_sw));
            end
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        done = 1'b1;
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        in_h = '{16, 20, 16, 20, 17, 19};
        in_v = '{8, 12, 8, 12, 9, 10};
        in_sw = 11; in_sh = 5; in_ns = 1'b0;
        fit_in = 32'h0;
        cycles(3);
        // R10: counters held at origin during reset
        chk(hcnt == 16'd0, "R10 reset hcnt", hcnt, 0);
        chk(vcnt == 16'd0, "R10 reset vcnt", vcnt, 0);
        rst = 1'b0;
        cycles(480);
        // switch to centred mode mid-frame (odd differences)
        cycles(37);
        in_ns = 1'b1;
        cycles(3 * 240);
        // new panel timing mid-frame, still centred
        cycles(55);
        in_h = '{12, 18, 12, 18, 13, 15};
        in_v = '{6, 9, 6, 9, 7, 8};
        in_sw = 7; in_sh = 3;
        cycles(3 * 162 + 40);
        in_ns = 1'b0;
        cycles(2 * 162);
        // R10: reset mid-frame returns counters to origin
        rst = 1'b1;
        cycles(2);
        chk(hcnt == 16'd0 && vcnt == 16'd0, "R10 mid reset", {hcnt, vcnt}, 0);
        rst = 1'b0;
        cycles(200);
        // R9: fitter guard, enable bit 31, pipe field 30:29
        fit_in = {1'b1, PIPE, 29'h1234};
        #1 chk(fit_out == 32'd0, "R9 owned cleared", fit_out, 0);
        fit_in = {1'b1, 2'd1, 29'h1234};
        #1 chk(fit_out == fit_in, "R9 other pipe kept", fit_out, fit_in);
        fit_in = {1'b0, PIPE, 29'h0abc};
        #1 chk(fit_out == fit_in, "R9 disabled kept", fit_out, fit_in);
        fit_in = {1'b1, 2'd3, 29'h1};
        #1 chk(fit_out == fit_in, "R9 pipe3 kept", fit_out, fit_in);
        cycles(2);
        done = 1'b1;
        finish_run();
    end
endmodule